// File: doc/BRIEF.md
# Double-Error-Correcting BCH(63,51) Decoder

This block takes one 63-bit word of a binary BCH code with length 63 and designed distance 5. The word arrives as eight bytes. The block repairs up to two flipped bits anywhere in the word and returns the 51 message bits together with one status flag.

Inside, the work runs as three phases, one after the other:
- **Syndromes.** Four syndromes over GF(2^6) are gathered one byte per cycle while the word streams in.
- **Locator solve.** An inversionless Berlekamp-Massey solver, reduced to two iterations for a binary code with t = 2, produces a locator polynomial of degree at most two.
- **Chien search.** The search tests eight bit positions per cycle. Each root it finds flips the matching received bit.

The decoder holds one word at a time. A new word can start in the same cycle in which the previous result is shown.

Top module: `bch2_decoder`

## Requirements
- R1: A word enters as eight bytes on eight consecutive cycles, starting with a cycle where in_valid is high while the decoder is idle. Byte 0 carries r62..r56 in bits 6..0 and byte 7 carries r7..r0. In general, bit b of byte k is received bit r(56-8k+b). Bit 7 of byte 0 is padding and has no effect on any result.
- R2: Codewords are those of the cyclic code with generator x^12+x^10+x^8+x^5+x^4+x^3+1, with field arithmetic modulo x^6+x+1. The message occupies c62..c12, and out_msg bit i equals c(12+i). An error-free word returns its message with out_clean set.
- R3: A single flipped bit at any of the 63 positions is repaired: out_msg equals the sent message and out_fixed is set.
- R4: Any two flipped bits are repaired, including pairs that straddle a byte boundary or sit at the ends of the word. out_msg equals the sent message and out_fixed is set.
- R5: When the syndromes are nonzero but the locator has degree zero, or the number of roots found differs from its degree, out_fail is set. In that case out_msg carries the received bits r62..r12 unmodified. Flips at positions {0,1,6} or {12,13,18} always produce this case.
- R6: A word with three flipped bits never reports out_clean. If it reports out_fixed, out_msg differs from the sent message.
- R7: With every result exactly one of out_clean, out_fixed, out_fail is high.
- R8: out_valid is a one-cycle pulse that rises on the 18th rising edge after the edge that accepts byte 0. Counting the cycle in which byte 0 is presented as the first, this is the twentieth cycle.
- R9: in_valid and in_byte are ignored from the edge after byte 7 is taken until the result edge. The next word may be presented in the cycle where out_valid is high.
- R10: After reset, out_valid, out_msg and all flags are zero. Between pulses, out_msg and the flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Starts a word when the decoder is idle |
| in_byte | input | 8 | Received word byte, first byte first |
| out_valid | output | 1 | One-cycle result strobe |
| out_msg | output | 51 | Decoded message bits c62..c12 |
| out_clean | output | 1 | All syndromes were zero |
| out_fixed | output | 1 | One or two bits were flipped back |
| out_fail | output | 1 | Error pattern beyond repair |

## Verification
Every one of the 63 single-error positions is visited. A wrong lane constant in the syndrome or Chien unit would then mis-repair a specific position, and a misplaced padding mask would break position 62.

Double errors are placed at the two ends of the word, across byte boundaries, and at random. A solver with a wrong discrepancy term or the wrong shift of its auxiliary polynomial would return a locator whose roots do not match its degree, so such words would fail instead of being repaired.

The patterns {0,1,6} and {12,13,18} force a first syndrome of zero with a third syndrome that is nonzero. A decoder that does not check the locator degree would call these words repaired. One that flips bits anyway would alter bits 0, 1 and 6 of the returned message.

Junk bytes sent while the decoder is busy, and words sent back to back, expose any acceptance outside the idle state.

// File: rtl/bchdec_pkg.sv
package bchdec_pkg;
    localparam int GF_M      = 6;
    localparam logic [GF_M:0] GF_POLY = 7'b100_0011;     // x^6 + x + 1
    localparam int GF_ORDER  = (1 << GF_M) - 1;
    localparam int CW_BITS   = GF_ORDER;
    localparam int PAR_BITS  = 12;
    localparam int MSG_BITS  = CW_BITS - PAR_BITS;
    localparam int LANES     = 8;
    localparam int N_BYTES   = (CW_BITS + LANES - 1) / LANES;
    localparam int RX_BITS   = N_BYTES * LANES;
    localparam int PAD_BITS  = RX_BITS - CW_BITS;
    localparam int T_CORR    = 2;                          // solver structure assumes 2
    localparam int N_SYN     = 2 * T_CORR;
    localparam int LOC_TERMS = T_CORR + 1;
    localparam int CNT_W     = $clog2(N_BYTES + 1);
    localparam int LATENCY   = 2 * N_BYTES + T_CORR;      // edges from accept to result

    typedef logic [GF_M-1:0] gf_t;
    typedef logic [N_SYN-1:0][GF_M-1:0] syn_vec_t;        // [0] holds S1
    typedef logic [LOC_TERMS-1:0][GF_M-1:0] loc_poly_t;   // index = degree

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_SOLVE  = 3'd2,
        ST_SEARCH = 3'd3,
        ST_FINISH = 3'd4
    } dec_state_e;

    // multiply by alpha
    function automatic gf_t gf_xalpha(gf_t a);
        return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_POLY[GF_M-1:0] : gf_t'(0));
    endfunction

    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc;
        gf_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < GF_M; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xalpha(sh);
        end
        return acc;
    endfunction

    // alpha^e for any integer e, negative allowed
    function automatic gf_t gf_pow(int e);
        int  r;
        gf_t v;
        r = e % GF_ORDER;
        if (r < 0) r = r + GF_ORDER;
        v = gf_t'(1);
        for (int i = 0; i < GF_ORDER; i++) begin
            if (i < r) v = gf_xalpha(v);
        end
        return v;
    endfunction
endpackage

// File: rtl/bchdec_syndrome.sv
// Byte-parallel Horner step: S_i <- S_i * a^(8i) + sum_b bit_b * a^(i*b)
module bchdec_syndrome
    import bchdec_pkg::*;
(
    input  syn_vec_t          syn_cur,
    input  logic [LANES-1:0]  byte_in,
    output syn_vec_t          syn_nxt
);
    for (genvar i = 0; i < N_SYN; i++) begin : g_syn
        localparam gf_t STEP = gf_pow(LANES * (i + 1));
        gf_t acc;
        always_comb begin
            acc = gf_mul(syn_cur[i], STEP);
            for (int b = 0; b < LANES; b++) begin
                if (byte_in[b]) acc = acc ^ gf_pow(b * (i + 1));
            end
        end
        assign syn_nxt[i] = acc;
    end
endmodule

// File: rtl/bchdec_kes_step.sv
// One iteration of the binary inversionless Berlekamp-Massey update.
// Two calls cover t = 2; the auxiliary polynomial is kept pre-shifted.
module bchdec_kes_step
    import bchdec_pkg::*;
(
    input  syn_vec_t   syn,
    input  logic       second,
    input  loc_poly_t  lam,
    input  loc_poly_t  bpoly,
    input  gf_t        gamma,
    output loc_poly_t  lam_nxt,
    output loc_poly_t  bpoly_nxt,
    output gf_t        gamma_nxt
);
    gf_t       delta;
    loc_poly_t src;

    always_comb begin
        int idx;
        delta = '0;
        for (int j = 0; j < LOC_TERMS; j++) begin
            idx = (second ? 2 : 0) - j;
            if (idx >= 0) delta = delta ^ gf_mul(lam[j], syn[idx]);
        end
    end

    always_comb begin
        for (int j = 0; j < LOC_TERMS; j++) begin
            lam_nxt[j] = gf_mul(gamma, lam[j]) ^ gf_mul(delta, bpoly[j]);
        end
        src       = (delta != '0) ? lam : bpoly;
        gamma_nxt = (delta != '0) ? delta : gamma;
        bpoly_nxt = '0;
        for (int j = 2; j < LOC_TERMS; j++) begin
            bpoly_nxt[j] = src[j-2];
        end
    end
endmodule

// File: rtl/bchdec_chien.sv
// Tests LANES positions per call; lane b of pass c checks position 8c+b
// by evaluating the locator at alpha^-(8c+b).
module bchdec_chien
    import bchdec_pkg::*;
(
    input  loc_poly_t         lam,
    input  gf_t               term1,
    input  gf_t               term2,
    output logic [LANES-1:0]  hit,
    output gf_t               term1_nxt,
    output gf_t               term2_nxt
);
    localparam gf_t STEP1 = gf_pow(-LANES);
    localparam gf_t STEP2 = gf_pow(-2 * LANES);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        localparam gf_t W1 = gf_pow(-b);
        localparam gf_t W2 = gf_pow(-2 * b);
        assign hit[b] = ((lam[0] ^ gf_mul(term1, W1) ^ gf_mul(term2, W2)) == '0);
    end

    assign term1_nxt = gf_mul(term1, STEP1);
    assign term2_nxt = gf_mul(term2, STEP2);
endmodule

// File: rtl/bch2_decoder.sv
module bch2_decoder
    import bchdec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [LANES-1:0]     in_byte,
    output logic                 out_valid,
    output logic [MSG_BITS-1:0]  out_msg,
    output logic                 out_clean,
    output logic                 out_fixed,
    output logic                 out_fail
);
    typedef struct packed {
        dec_state_e            state;
        logic [CNT_W-1:0]      cnt;
        logic [RX_BITS-1:0]    rx;
        syn_vec_t              syn;
        loc_poly_t             lam;
        loc_poly_t             bpoly;
        gf_t                   gamma;
        gf_t                   term1;
        gf_t                   term2;
        logic [RX_BITS-1:0]    err;
        logic                  valid;
        logic [MSG_BITS-1:0]   msg;
        logic                  clean;
        logic                  fixed;
        logic                  fail;
    } dec_regs_t;

    localparam logic [LANES-1:0] FIRST_MASK = {{PAD_BITS{1'b0}}, {(LANES-PAD_BITS){1'b1}}};

    dec_regs_t         q, d;
    logic [LANES-1:0]  byte_m;
    syn_vec_t          syn_in, syn_nxt;
    loc_poly_t         lam_nxt, bpoly_nxt;
    gf_t               gamma_nxt, term1_nxt, term2_nxt;
    logic [LANES-1:0]  hit;

    assign byte_m = (q.state == ST_IDLE) ? (in_byte & FIRST_MASK) : in_byte;
    assign syn_in = (q.state == ST_IDLE) ? '0 : q.syn;

    bchdec_syndrome i_syn (
        .syn_cur (syn_in),
        .byte_in (byte_m),
        .syn_nxt (syn_nxt)
    );

    bchdec_kes_step i_kes (
        .syn       (q.syn),
        .second    (q.cnt[0]),
        .lam       (q.lam),
        .bpoly     (q.bpoly),
        .gamma     (q.gamma),
        .lam_nxt   (lam_nxt),
        .bpoly_nxt (bpoly_nxt),
        .gamma_nxt (gamma_nxt)
    );

    bchdec_chien i_chien (
        .lam       (q.lam),
        .term1     (q.term1),
        .term2     (q.term2),
        .hit       (hit),
        .term1_nxt (term1_nxt),
        .term2_nxt (term2_nxt)
    );

    always_comb begin
        int                  deg;
        int                  roots;
        logic                syn_nz;
        logic                bad;
        logic [CW_BITS-1:0]  word;
        d       = q;
        d.valid = 1'b0;
        deg     = (q.lam[2] != '0) ? 2 : ((q.lam[1] != '0) ? 1 : 0);
        roots   = $countones(q.err[CW_BITS-1:0]);
        syn_nz  = (q.syn != '0);
        bad     = syn_nz && (deg == 0 || roots != deg);
        word    = q.rx[CW_BITS-1:0] ^ ((syn_nz && !bad) ? q.err[CW_BITS-1:0] : '0);
        case (q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    d.rx    = {q.rx[RX_BITS-LANES-1:0], byte_m};
                    d.syn   = syn_nxt;
                    d.cnt   = CNT_W'(1);
                    d.state = ST_LOAD;
                end
            end
            ST_LOAD: begin
                d.rx  = {q.rx[RX_BITS-LANES-1:0], byte_m};
                d.syn = syn_nxt;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(N_BYTES - 1)) begin
                    d.state    = ST_SOLVE;
                    d.cnt      = '0;
                    d.lam      = '0;
                    d.lam[0]   = gf_t'(1);
                    d.bpoly    = '0;
                    d.bpoly[1] = gf_t'(1);
                    d.gamma    = gf_t'(1);
                    d.err      = '0;
                end
            end
            ST_SOLVE: begin
                d.lam   = lam_nxt;
                d.bpoly = bpoly_nxt;
                d.gamma = gamma_nxt;
                d.cnt   = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(T_CORR - 1)) begin
                    d.state = ST_SEARCH;
                    d.cnt   = '0;
                    d.term1 = lam_nxt[1];
                    d.term2 = lam_nxt[2];
                end
            end
            ST_SEARCH: begin
                d.err[int'(q.cnt)*LANES +: LANES] = hit;
                d.term1 = term1_nxt;
                d.term2 = term2_nxt;
                d.cnt   = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(N_BYTES - 1)) d.state = ST_FINISH;
            end
            ST_FINISH: begin
                d.valid = 1'b1;
                d.msg   = word[CW_BITS-1:PAR_BITS];
                d.clean = !syn_nz;
                d.fixed = syn_nz && !bad;
                d.fail  = bad;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.valid;
    assign out_msg   = q.msg;
    assign out_clean = q.clean;
    assign out_fixed = q.fixed;
    assign out_fail  = q.fail;
endmodule

// File: rtl/bch2_decoder_checks.sv
module bch2_decoder_checks
    import bchdec_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [MSG_BITS-1:0]  out_msg,
    input logic                 out_clean,
    input logic                 out_fixed,
    input logic                 out_fail
);
    localparam int TRK_W = $clog2(LATENCY + 1);

    logic [TRK_W-1:0] trk_q;
    logic             exp_q;

    // independent model of acceptance and result timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (trk_q == TRK_W'(LATENCY)) begin
                trk_q <= '0;
                exp_q <= 1'b1;
            end else if (trk_q != '0) begin
                trk_q <= trk_q + 1'b1;
            end else if (in_valid) begin
                trk_q <= TRK_W'(1);
            end
        end
    end

    a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_clean, out_fixed, out_fail}) == 1);

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == exp_q);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable({out_msg, out_clean, out_fixed, out_fail}));
endmodule

bind bch2_decoder bch2_decoder_checks i_checks (.*);

// File: tb/test_bch2_decoder.sv
`timescale 1ns/1ps
module test_bch2_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        out_valid;
    logic [50:0] out_msg;
    logic        out_clean, out_fixed, out_fail;

    bch2_decoder i_bch2_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .out_valid (out_valid),
        .out_msg   (out_msg),
        .out_clean (out_clean),
        .out_fixed (out_fixed),
        .out_fail  (out_fail)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int n_chk = 0;
    int n_bad = 0;

    // kind: 0 clean, 1 repaired, 2 beyond repair, 3 triple error
    typedef struct {
        logic [50:0] data;
        logic [50:0] sent;
        int          kind;
        int          start;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // systematic encoder from the generator polynomial (R2)
    function automatic logic [62:0] encode(logic [50:0] msg);
        logic [11:0] rem;
        logic        fb;
        rem = '0;
        for (int i = 50; i >= 0; i--) begin
            fb  = msg[i] ^ rem[11];
            rem = {rem[10:0], 1'b0} ^ (fb ? 12'h539 : 12'h000);
        end
        return {msg, rem};
    endfunction

    task automatic send(logic [50:0] msg, logic [62:0] flips, bit pad, bit junk,
                        int kind, string tag);
        logic [62:0] rx;
        logic [63:0] full;
        exp_t        e;
        rx     = encode(msg) ^ flips;
        full   = {pad, rx};
        e.sent = msg;
        e.data = (kind == 2) ? rx[62:12] : msg;
        e.kind = kind;
        e.tag  = tag;
        @(negedge clk);
        e.start = cyc;
        sb.push_back(e);
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            in_valid = 1'b1;
            in_byte  = full[63-8*k -: 8];
        end
        for (int k = 0; k < 11; k++) begin
            @(negedge clk);
            in_valid = junk;
            in_byte  = 8'($urandom());
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8 result with nothing pending", 64'(out_valid), 64'(0));
                end else begin
                    exp_t        e;
                    logic [50:0] held;
                    logic [2:0]  flags;
                    e     = sb.pop_front();
                    flags = {out_clean, out_fixed, out_fail};
                    held  = out_msg;
                    check(cyc - e.start == 19, "R8 latency", 64'(cyc - e.start), 64'(19));
                    check($countones(flags) == 1, "R7 one flag", 64'(flags), 64'(0));
                    case (e.kind)
                        0: begin
                            check(flags == 3'b100, {e.tag, " clean flag"}, 64'(flags), 64'(3'b100));
                            check(out_msg == e.data, {e.tag, " clean data"}, 64'(out_msg), 64'(e.data));
                        end
                        1: begin
                            check(flags == 3'b010, {e.tag, " fixed flag"}, 64'(flags), 64'(3'b010));
                            check(out_msg == e.data, {e.tag, " fixed data"}, 64'(out_msg), 64'(e.data));
                        end
                        2: begin
                            check(flags == 3'b001, {e.tag, " fail flag"}, 64'(flags), 64'(3'b001));
                            check(out_msg == e.data, {e.tag, " raw data"}, 64'(out_msg), 64'(e.data));
                        end
                        default: begin
                            check(!out_clean, "R6 triple not clean", 64'(flags), 64'(3'b010));
                            if (out_fixed)
                                check(out_msg != e.sent, "R6 miscorrection differs", 64'(out_msg), 64'(e.sent));
                        end
                    endcase
                    @(negedge clk);
                    check(!out_valid, "R8 single pulse", 64'(out_valid), 64'(0));
                    check(out_msg == held && {out_clean, out_fixed, out_fail} == flags,
                          "R10 hold", 64'(out_msg), 64'(held));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int p1, p2, p3;
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0 && out_msg == '0, "R10 reset outputs", 64'(out_msg), 64'(0));
        check({out_clean, out_fixed, out_fail} == 3'b000, "R10 reset flags",
              64'({out_clean, out_fixed, out_fail}), 64'(0));
        rst_n = 1'b1;

        // clean words
        send('0, '0, 1'b0, 1'b0, 0, "R2");
        send('1, '0, 1'b0, 1'b0, 0, "R2");
        for (int k = 0; k < 3; k++) send(51'({$urandom(), $urandom()}), '0, 1'b0, 1'b0, 0, "R2");
        send(51'({$urandom(), $urandom()}), '0, 1'b1, 1'b0, 0, "R1 pad");
        send(51'({$urandom(), $urandom()}), '0, 1'b0, 1'b1, 0, "R9 junk");

        // every single-error position
        for (int p = 0; p < 63; p++)
            send(51'({$urandom(), $urandom()}), 63'(1) << p, p == 62, (p % 4) == 0, 1,
                 (p == 62 || p == 0) ? "R1 R3 end" : "R3");

        // double errors
        send(51'({$urandom(), $urandom()}), (63'(1) << 0) | (63'(1) << 62), 1'b0, 1'b0, 1, "R4 ends");
        send(51'({$urandom(), $urandom()}), (63'(1) << 7) | (63'(1) << 8), 1'b0, 1'b1, 1, "R4 boundary");
        send(51'({$urandom(), $urandom()}), (63'(1) << 55) | (63'(1) << 56), 1'b0, 1'b0, 1, "R4 boundary");
        send(51'({$urandom(), $urandom()}), (63'(1) << 61) | (63'(1) << 62), 1'b0, 1'b0, 1, "R4 top");
        for (int k = 0; k < 30; k++) begin
            p1 = int'($urandom() % 63);
            do p2 = int'($urandom() % 63); while (p2 == p1);
            send(51'({$urandom(), $urandom()}), (63'(1) << p1) | (63'(1) << p2), 1'b0, k % 3 == 0, 1, "R4");
        end

        // locator of degree zero
        send(51'({$urandom(), $urandom()}), (63'(1) << 0) | (63'(1) << 1) | (63'(1) << 6),
             1'b0, 1'b0, 2, "R5");
        send(51'({$urandom(), $urandom()}), (63'(1) << 12) | (63'(1) << 13) | (63'(1) << 18),
             1'b0, 1'b1, 2, "R5");

        // random triple errors
        for (int k = 0; k < 25; k++) begin
            p1 = int'($urandom() % 63);
            do p2 = int'($urandom() % 63); while (p2 == p1);
            do p3 = int'($urandom() % 63); while (p3 == p1 || p3 == p2);
            send(51'({$urandom(), $urandom()}),
                 (63'(1) << p1) | (63'(1) << p2) | (63'(1) << p3), 1'b0, 1'b0, 3, "R6");
        end

        @(negedge clk);
        in_valid = 1'b0;
        repeat (40) @(negedge clk);
        check(sb.size() == 0, "R8 all results seen", 64'(sb.size()), 64'(0));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule